// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block holds a bank of programmable address windows and sorts incoming bus request addresses into target identifiers. Each window has a control word and a base word. The control word holds an enable flag, an 8-bit target attribute and a size count. The base word holds the upper half of the window's start address. Software programs these words through a small register port: one write strobe, a word address and 32-bit data, with reads returned combinationally.

For each request the decoder compares the upper 16 address bits against every enabled window. It compares only the bits that the window's size mask does not cover. One clock after the request strobe it reports one of two results. On a hit it returns the matching window's attribute and index. On a miss it says that no enabled window matched. When windows overlap, the lowest-numbered window is chosen and a multi-hit flag is raised.

Window sizes are powers of two in 64 KB steps. The size field is written as the unit count minus one, so it is a run of ones starting at its least significant bit. Software writes the fields with the enable flag clear and then sets the flag in a second write.

Top module: `addr_win_decoder`

## Requirements
- R1: After reset every control and base register reads zero. A request then decodes as a miss, and `dec_valid`, `dec_hit` and `dec_multi` are low until the first request.
- R2: The control word of window n is at word address 2n and its base word is at 2n+1. A base word reads back exactly as written.
- R3: A control word stores only bit 0 (enable), bits 15:8 (attribute) and bits 23:16 (size). Bits 7:1 and 31:24 read as zero whatever was written.
- R4: A window whose enable bit is clear never produces a hit, even when its base and size would match the address.
- R5: An address hits window n when its bits 31:16 equal base bits 31:16 in every position not covered by the mask formed from {8'h00, size}. Size 0 gives a 64 KB window, size 8'h0F gives 1 MB, and base bits 15:0 are ignored.
- R6: On a hit, `dec_attr` carries bits 15:8 of the matching window's control word and `dec_idx` carries its index.
- R7: When no enabled window matches, `dec_miss` is 1, `dec_hit` is 0, and `dec_attr` and `dec_idx` are 0. When `dec_valid` is high, exactly one of `dec_hit` and `dec_miss` is high.
- R8: When more than one enabled window matches, the lowest index wins and `dec_multi` is 1. With exactly one match, `dec_multi` is 0.
- R9: The result appears in the clock cycle after `req_valid` is sampled high, with `dec_valid` high for exactly that one cycle. Otherwise `dec_valid`, `dec_hit`, `dec_miss` and `dec_multi` are low.
- R10: A request sampled on the same clock edge as a register write is decoded with the register contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register word address (window index, then word select in bit 0) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Request address |
| dec_valid | output | 1 | Decode result valid |
| dec_hit | output | 1 | An enabled window matched |
| dec_miss | output | 1 | No enabled window matched |
| dec_multi | output | 1 | More than one enabled window matched |
| dec_attr | output | 8 | Attribute of the chosen window |
| dec_idx | output | 3 | Index of the chosen window |

## Verification
Two functions can land on the same clock edge: a register write and a request decode. The bench provokes this in two ways. It sets the enable bit of a prepared window in the same cycle as a request to that window's address, and it clears the enable of a live window in the same cycle as a request that hits it. The decode must reflect the old state in both cases: a miss for the first and a hit for the second. The next request must then show the new state.

// File: rtl/addr_win_pkg.sv
package addr_win_pkg;

    localparam int DATA_W   = 32;
    localparam int PAGE_W   = 16;
    localparam int PAGE_LSB = 16;
    localparam int ATTR_W   = 8;
    localparam int SIZE_W   = 8;

    typedef struct packed {
        logic [SIZE_W-1:0] size;
        logic [ATTR_W-1:0] attr;
        logic              en;
    } win_ctrl_t;

    function automatic win_ctrl_t ctrl_from_word(input logic [DATA_W-1:0] w);
        win_ctrl_t c;
        c.en   = w[0];
        c.attr = w[15:8];
        c.size = w[23:16];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_word(input win_ctrl_t c);
        return {8'h00, c.size, c.attr, 7'h00, c.en};
    endfunction

    function automatic logic page_match(input logic [PAGE_W-1:0] req_page,
                                        input logic [PAGE_W-1:0] base_page,
                                        input logic [SIZE_W-1:0] size);
        logic [PAGE_W-1:0] care;
        care = ~{{(PAGE_W-SIZE_W){1'b0}}, size};
        return ((req_page ^ base_page) & care) == '0;
    endfunction

endpackage

// File: rtl/win_regfile.sv
module win_regfile
    import addr_win_pkg::*;
#(
    parameter int NUM_WIN = 8,
    localparam int IDX_W  = $clog2(NUM_WIN),
    localparam int AW     = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output win_ctrl_t         ctrl_o [NUM_WIN],
    output logic [PAGE_W-1:0] base_page_o [NUM_WIN]
);

    logic [DATA_W-1:0] base_q [NUM_WIN];
    win_ctrl_t         ctrl_q [NUM_WIN];

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        logic sel;
        assign sel = cfg_wr && (cfg_addr[AW-1:1] == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                ctrl_q[i] <= '0;
                base_q[i] <= '0;
            end else if (sel) begin
                if (cfg_addr[0]) base_q[i] <= cfg_wdata;
                else             ctrl_q[i] <= ctrl_from_word(cfg_wdata);
            end
        end

        assign ctrl_o[i]      = ctrl_q[i];
        assign base_page_o[i] = base_q[i][PAGE_LSB +: PAGE_W];
    end

    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (cfg_addr[AW-1:1] == IDX_W'(i))
                cfg_rdata = cfg_addr[0] ? base_q[i] : ctrl_to_word(ctrl_q[i]);
        end
    end

    // R2 / R3: a written word reads back (masked for control) in the next cycle
    assert_readback_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && int'(cfg_addr[AW-1:1]) < NUM_WIN) |=>
            (!$stable(cfg_addr) || $past(cfg_wr && cfg_addr != cfg_addr) ||
             cfg_rdata == ($past(cfg_addr[0]) ? $past(cfg_wdata)
                                              : ($past(cfg_wdata) & 32'h00FF_FF01))));

endmodule

// File: rtl/win_match.sv
module win_match
    import addr_win_pkg::*;
#(
    parameter int NUM_WIN = 8
) (
    input  logic [DATA_W-1:0] req_addr,
    input  win_ctrl_t         ctrl_i [NUM_WIN],
    input  logic [PAGE_W-1:0] base_page_i [NUM_WIN],
    output logic [NUM_WIN-1:0] hit_vec
);

    logic [PAGE_W-1:0] req_page;
    assign req_page = req_addr[PAGE_LSB +: PAGE_W];

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
        assign hit_vec[i] = ctrl_i[i].en &&
                            page_match(req_page, base_page_i[i], ctrl_i[i].size);
    end

endmodule

// File: rtl/win_prio.sv
module win_prio #(
    parameter int NUM_WIN = 8,
    localparam int IDX_W  = $clog2(NUM_WIN)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_WIN-1:0] hit_vec,
    output logic               any_hit,
    output logic               multi_hit,
    output logic [IDX_W-1:0]   win_idx
);

    always_comb begin
        win_idx = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit_vec[i]) win_idx = IDX_W'(i);
        end
    end

    assign any_hit   = |hit_vec;
    assign multi_hit = $countones(hit_vec) > 1;

    // R8: the chosen window is itself a hit and no lower window hits
    assert_lowest_wins_R8: assert property (@(posedge clk) disable iff (rst)
        any_hit |-> (hit_vec[win_idx] &&
                     ((hit_vec & ((NUM_WIN'(1) << win_idx) - NUM_WIN'(1))) == '0)));

endmodule

// File: rtl/addr_win_decoder.sv
module addr_win_decoder
    import addr_win_pkg::*;
#(
    parameter int NUM_WIN = 8,
    localparam int IDX_W  = $clog2(NUM_WIN),
    localparam int AW     = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              req_valid,
    input  logic [DATA_W-1:0] req_addr,
    output logic              dec_valid,
    output logic              dec_hit,
    output logic              dec_miss,
    output logic              dec_multi,
    output logic [ATTR_W-1:0] dec_attr,
    output logic [IDX_W-1:0]  dec_idx
);

    win_ctrl_t         ctrl    [NUM_WIN];
    logic [PAGE_W-1:0] base_pg [NUM_WIN];
    logic [NUM_WIN-1:0] hit_vec;
    logic               any_hit, multi_hit;
    logic [IDX_W-1:0]   win_idx;

    win_regfile #(.NUM_WIN(NUM_WIN)) u_regs (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .ctrl_o(ctrl), .base_page_o(base_pg)
    );

    win_match #(.NUM_WIN(NUM_WIN)) u_match (
        .req_addr(req_addr), .ctrl_i(ctrl), .base_page_i(base_pg), .hit_vec(hit_vec)
    );

    win_prio #(.NUM_WIN(NUM_WIN)) u_prio (
        .clk(clk), .rst(rst), .hit_vec(hit_vec),
        .any_hit(any_hit), .multi_hit(multi_hit), .win_idx(win_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid <= 1'b0;
            dec_hit   <= 1'b0;
            dec_miss  <= 1'b0;
            dec_multi <= 1'b0;
            dec_attr  <= '0;
            dec_idx   <= '0;
        end else begin
            dec_valid <= req_valid;
            dec_hit   <= req_valid && any_hit;
            dec_miss  <= req_valid && !any_hit;
            dec_multi <= req_valid && multi_hit;
            if (req_valid) begin
                dec_attr <= any_hit ? ctrl[win_idx].attr : '0;
                dec_idx  <= any_hit ? win_idx : '0;
            end
        end
    end

    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> dec_valid);

    assert_valid_drops_R9: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!dec_valid && !dec_hit && !dec_miss && !dec_multi));

    assert_hit_xor_miss_R7: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> (dec_hit != dec_miss));

    assert_miss_zero_R7: assert property (@(posedge clk) disable iff (rst)
        dec_miss |-> (dec_attr == '0 && dec_idx == '0));

    assert_multi_needs_hit_R8: assert property (@(posedge clk) disable iff (rst)
        dec_multi |-> dec_hit);

endmodule

// File: tb/addr_win_decoder_tb_top.sv
`timescale 1ns/1ps
module addr_win_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        dec_valid, dec_hit, dec_miss, dec_multi;
    logic [7:0]  dec_attr;
    logic [2:0]  dec_idx;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    addr_win_decoder dut_i (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_addr(req_addr),
        .dec_valid(dec_valid), .dec_hit(dec_hit), .dec_miss(dec_miss),
        .dec_multi(dec_multi), .dec_attr(dec_attr), .dec_idx(dec_idx)
    );

    // {addr, attr, idx(4), 2'b0, hit, multi}
    localparam int NV = 12;
    localparam logic [47:0] VEC [NV] = '{
        {32'h8000_0000, 8'h11, 4'd0, 2'b00, 1'b1, 1'b0},
        {32'h8000_FFFF, 8'h11, 4'd0, 2'b00, 1'b1, 1'b0},
        {32'h8001_0000, 8'h00, 4'd0, 2'b00, 1'b0, 1'b0},
        {32'h4005_1234, 8'h22, 4'd2, 2'b00, 1'b1, 1'b1},
        {32'h400F_FFFF, 8'h22, 4'd2, 2'b00, 1'b1, 1'b1},
        {32'h4010_0000, 8'h33, 4'd3, 2'b00, 1'b1, 1'b0},
        {32'h40FF_0000, 8'h33, 4'd3, 2'b00, 1'b1, 1'b0},
        {32'h4100_0000, 8'h00, 4'd0, 2'b00, 1'b0, 1'b0},
        {32'h1234_5678, 8'h00, 4'd0, 2'b00, 1'b0, 1'b0},
        {32'hF003_0000, 8'h77, 4'd7, 2'b00, 1'b1, 1'b0},
        {32'hF004_0000, 8'h00, 4'd0, 2'b00, 1'b0, 1'b0},
        {32'h0000_0000, 8'h00, 4'd0, 2'b00, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [3:0] a, input logic [31:0] exp);
        cfg_addr = a;
        #1;
        check(req, cfg_rdata, exp);
    endtask

    task automatic do_req(input logic [31:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic check_result(input string req, input logic hit, input logic multi,
                                input logic [7:0] attr, input logic [3:0] idx);
        check({req, " valid"}, 32'(dec_valid), 32'd1);
        check({req, " hit"},   32'(dec_hit),   32'(hit));
        check({req, " miss"},  32'(dec_miss),  32'(!hit));
        check({req, " multi"}, 32'(dec_multi), 32'(multi));
        check({req, " attr"},  32'(dec_attr),  32'(attr));
        check({req, " idx"},   32'(dec_idx),   32'(idx));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check("R1 dec_valid after reset", 32'(dec_valid), 32'd0);
        check("R1 dec_hit after reset",   32'(dec_hit),   32'd0);
        check("R1 dec_multi after reset", 32'(dec_multi), 32'd0);
        for (int a = 0; a < 16; a++) rd_check("R1 register zero", 4'(a), 32'h0);
        do_req(32'h0000_0000);
        check_result("R1 request before programming", 1'b0, 1'b0, 8'h00, 4'd0);

        // program windows, enable in a second write
        wr(4'd1,  32'h8000_ABCD); wr(4'd0,  32'h0000_1100); wr(4'd0,  32'h0000_1101);
        wr(4'd5,  32'h4000_0000); wr(4'd4,  32'h000F_2200); wr(4'd4,  32'h000F_2201);
        wr(4'd7,  32'h4000_0000); wr(4'd6,  32'h00FF_3300); wr(4'd6,  32'h00FF_3301);
        wr(4'd11, 32'h1234_0000); wr(4'd10, 32'h0000_5500);
        wr(4'd15, 32'hF000_0000); wr(4'd14, 32'h0003_7700); wr(4'd14, 32'h0003_7701);
        wr(4'd2,  32'hFFFF_FFFE);

        // R2 / R3: register map and readback
        rd_check("R2 base word window 0",   4'd1,  32'h8000_ABCD);
        rd_check("R2 ctrl word window 0",   4'd0,  32'h0000_1101);
        rd_check("R2 base word window 7",   4'd15, 32'hF000_0000);
        rd_check("R3 unused ctrl bits zero", 4'd2, 32'h00FF_FF00);

        // vector table: R4 R5 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            do_req(VEC[v][47:16]);
            check_result($sformatf("R5/R6/R7/R8/R4 vector %0d", v),
                         VEC[v][1], VEC[v][0], VEC[v][15:8], VEC[v][7:4]);
        end

        // R9: valid lasts exactly one cycle
        do_req(32'hF000_0000);
        check("R9 dec_valid one cycle after request", 32'(dec_valid), 32'd1);
        @(negedge clk);
        check("R9 dec_valid drops", 32'(dec_valid), 32'd0);
        check("R9 dec_hit drops",   32'(dec_hit),   32'd0);
        check("R9 dec_miss drops",  32'(dec_miss),  32'd0);

        // R10: enable set in the same cycle as a request
        wr(4'd13, 32'h2000_0000); wr(4'd12, 32'h0000_6600);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 4'd12; cfg_wdata = 32'h0000_6601;
        req_valid = 1'b1; req_addr = 32'h2000_0000;
        @(negedge clk);
        cfg_wr = 1'b0; req_valid = 1'b0;
        check_result("R10 enable with same-cycle request", 1'b0, 1'b0, 8'h00, 4'd0);
        do_req(32'h2000_0000);
        check_result("R10 after enable", 1'b1, 1'b0, 8'h66, 4'd6);

        // R10: enable cleared in the same cycle as a request
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 4'd0; cfg_wdata = 32'h0000_1100;
        req_valid = 1'b1; req_addr = 32'h8000_1000;
        @(negedge clk);
        cfg_wr = 1'b0; req_valid = 1'b0;
        check_result("R10 disable with same-cycle request", 1'b1, 1'b0, 8'h11, 4'd0);
        do_req(32'h8000_1000);
        check_result("R4 after disable", 1'b0, 1'b0, 8'h00, 4'd0);

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule